// File: doc/BRIEF.md
# Dual-Master Peripheral Chip-Select Bridge

This block connects two host-side request sources to a narrow external peripheral bus with an 8-bit data path. One source issues I/O-style requests with a 16-bit address. The other issues 8-bit command codes from a serial management controller. A request from either side is decoded into one of four chip selects. The bridge then runs a fixed strobe sequence on the peripheral bus and returns a one-cycle completion pulse, with read data, to the side that issued the request.

Each of the four selects has a 14-bit base address that covers four consecutive ports. Selects 1 to 3 also carry an enable control and share a write-protect latch. Once firmware sets that latch, no later write can move or disable those selects until the next reset. Select 0 has no enable control and no latch, so it stays free for uses such as watching a fixed diagnostic port. Select 1 drives its pin active high for a display controller. The other three selects drive their pins active low.

Only one transaction can be on the bus at a time. A request that arrives while the bus is busy is dropped without any response. When both sides request in the same clock, the address-based side wins.

Top module: `pcb_bridge`

## Requirements
- R1: While reset is held and after it is released with no request, `xcs` reads 4'b1101 (every select inactive), `xrd_n` and `xwr_n` are 1, and `xd_oe`, `lpc_done` and `smb_done` are 0.
- R2: Select 1 is active when its pin `xcs[1]` is 1. Selects 0, 2 and 3 are active when their pins are 0.
- R3: A request on the address side hits select i when `lpc_addr[15:2]` equals that select's base address and the select is enabled. During the cycle, `xa` equals {2'b00, `lpc_addr[1:0]`}.
- R4: A request on the command side hits select i when `smb_cmd[7:4]` equals nibble i of `CMD_CODES` (default 0xA, 0xB, 0xC, 0xD for selects 0 to 3) and the select is enabled. During the cycle, `xa` equals `smb_cmd[3:0]`.
- R5: Count from the clock edge that accepts a hitting request. The select is active for 7 cycles. The strobe (`xrd_n` for a read, `xwr_n` for a write) is low in cycles 3 to 6. The master's done pulse is high in cycle 8. On a read, `rsp_rdata` holds the value of `xd_in` from the last strobe cycle.
- R6: On a write, `xd_oe` is 1 and `xd_out` holds the write data for all 7 select-active cycles. On a read, `xd_oe` stays 0.
- R7: Configuration byte layout. With `cfg_hi`=1, `cfg_wdata` sets base address bits [15:8]. With `cfg_hi`=0, `cfg_wdata[7:2]` sets base address bits [7:2], bit 0 = 1 disables the select and bit 1 = 1 sets the write-protect latch. Selects 1 to 3 come out of reset disabled with base 0. A disabled select never becomes active.
- R8: A low-byte write with bit 1 = 1 to select 1, 2 or 3 sets the write-protect latch. While the latch is set, writes to the base address and the disable bit of selects 1 to 3 are ignored, and no write can clear the latch. Only reset clears it.
- R9: Select 0 comes out of reset at base 0x0080. It is always enabled. Bits [1:0] of its low byte have no effect, and it can still be written while the write-protect latch is set.
- R10: If both sides request in the same clock, the address side is served and the command side gets no done pulse. A request that arrives while a transaction is running is ignored and gets no done pulse.
- R11: An accepted request that hits no enabled select activates no select and no strobe. Its master gets a done pulse in the next cycle, with `rsp_rdata` = 0xFF.
- R12: When several enabled selects match, only the lowest-numbered one becomes active. At most one select is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpc_req | input | 1 | Address-side request pulse |
| lpc_we | input | 1 | Address-side write (1) or read (0) |
| lpc_addr | input | 16 | Address-side I/O address |
| lpc_wdata | input | 8 | Address-side write data |
| lpc_done | output | 1 | Address-side completion pulse |
| smb_req | input | 1 | Command-side request pulse |
| smb_we | input | 1 | Command-side write (1) or read (0) |
| smb_cmd | input | 8 | Command code: upper nibble selects the chip, lower nibble is the address |
| smb_wdata | input | 8 | Command-side write data |
| smb_done | output | 1 | Command-side completion pulse |
| rsp_rdata | output | 8 | Read data returned with the done pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Select index being configured |
| cfg_hi | input | 1 | 1 = high base byte, 0 = low byte with control bits |
| cfg_wdata | input | 8 | Configuration write data |
| xcs | output | 4 | Chip-select pins, polarity per R2 |
| xa | output | 4 | Peripheral address |
| xrd_n | output | 1 | Read strobe, active low |
| xwr_n | output | 1 | Write strobe, active low |
| xd_out | output | 8 | Data driven toward the peripheral |
| xd_oe | output | 1 | Output enable for `xd_out` |
| xd_in | input | 8 | Data read from the peripheral |

## Verification
The bound checker enforces these properties on every cycle:
- At most one select is active, and the two strobes are never low together.
- A strobe or a driven data bus never appears without an active select.
- The address stays stable across the strobe.
- The two done pulses never coincide.
- The write-protect latch never falls once set.
- A select only becomes active if it was enabled when the request was accepted.

The bench scenarios are the only place that shows the rest:
- The exact cycle counts of the sequence and the timing of read data capture.
- Which select a given address or command code reaches.
- The byte layout of the configuration writes.
- That blocked writes really leave the old decode in place, and that a reset unlocks the latch.
- That the arbitration tie-break and the dropping of requests during a busy bus behave as R10 states.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // I/O address width and the part of it compared against a base register
  localparam int ADDR_W = 16;
  localparam int PORT_W = 2;
  localparam int BASE_W = ADDR_W - PORT_W;
  localparam int XA_W   = 4;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/pcb_cfg.sv
module pcb_cfg
  import pcb_pkg::*;
#(
  parameter int              N_CS      = 4,
  parameter logic [N_CS-1:0] LOCKABLE  = 4'b1110,
  parameter logic [ADDR_W-1:0] BASE0_RST = 16'h0080,
  localparam int             SEL_W     = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [SEL_W-1:0]               cfg_sel,
  input  logic                           cfg_hi,
  input  logic [DATA_W-1:0]              cfg_wdata,
  output logic [N_CS-1:0][BASE_W-1:0]    base,
  output logic [N_CS-1:0]                enable,
  output logic                           lock
);

  logic lock_q, lock_d;

  // Latch can only rise; a low-byte write to a lockable select with bit 1 sets it
  always_comb begin
    lock_d = lock_q;
    if (cfg_we && !cfg_hi && cfg_wdata[1] && LOCKABLE[cfg_sel]) begin
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;

  for (genvar i = 0; i < N_CS; i++) begin : g_sel
    logic              wr_ok;
    logic [BASE_W-1:0] base_q, base_d;

    assign wr_ok = cfg_we && (cfg_sel == SEL_W'(i)) && !(LOCKABLE[i] && lock_q);

    always_comb begin
      base_d = base_q;
      if (cfg_hi) begin
        base_d[BASE_W-1:BASE_W-DATA_W] = cfg_wdata;
      end else begin
        base_d[BASE_W-DATA_W-1:0] = cfg_wdata[DATA_W-1:PORT_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= (i == 0) ? BASE0_RST[ADDR_W-1:PORT_W] : '0;
      end else if (wr_ok) begin
        base_q <= base_d;
      end
    end

    assign base[i] = base_q;

    if (LOCKABLE[i]) begin : g_dis
      logic dis_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dis_q <= 1'b1;
        end else if (wr_ok && !cfg_hi) begin
          dis_q <= cfg_wdata[0];
        end
      end
      assign enable[i] = !dis_q;
    end else begin : g_fixed
      assign enable[i] = 1'b1;
    end
  end

endmodule

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int                N_CS      = 4,
  parameter logic [4*N_CS-1:0] CMD_CODES = 16'hDCBA,
  localparam int               SEL_W     = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic                        use_smb,
  input  logic [ADDR_W-1:0]           lpc_addr,
  input  logic [DATA_W-1:0]           smb_cmd,
  input  logic [N_CS-1:0][BASE_W-1:0] base,
  input  logic [N_CS-1:0]             enable,
  output logic                        hit,
  output logic [SEL_W-1:0]            sel,
  output logic [XA_W-1:0]             xa
);

  logic [N_CS-1:0] match;

  for (genvar i = 0; i < N_CS; i++) begin : g_cmp
    logic cmd_eq, addr_eq;
    assign cmd_eq   = (smb_cmd[DATA_W-1:XA_W] == CMD_CODES[4*i +: 4]);
    assign addr_eq  = (lpc_addr[ADDR_W-1:PORT_W] == base[i]);
    assign match[i] = enable[i] && (use_smb ? cmd_eq : addr_eq);
  end

  // Lowest index wins when several selects match
  always_comb begin
    hit = |match;
    sel = '0;
    for (int i = N_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel = SEL_W'(i);
      end
    end
  end

  assign xa = use_smb ? smb_cmd[XA_W-1:0]
                      : {{(XA_W-PORT_W){1'b0}}, lpc_addr[PORT_W-1:0]};

endmodule

// File: rtl/pcb_seq.sv
module pcb_seq
  import pcb_pkg::*;
#(
  parameter int  N_CS       = 4,
  parameter int  SETUP_CYC  = 2,
  parameter int  STROBE_CYC = 4,
  parameter int  HOLD_CYC   = 1,
  localparam int SEL_W      = (N_CS > 1) ? $clog2(N_CS) : 1,
  localparam int CNT_W      = $clog2(SETUP_CYC + STROBE_CYC + HOLD_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpc_req,
  input  logic              lpc_we,
  input  logic [DATA_W-1:0] lpc_wdata,
  input  logic              smb_req,
  input  logic              smb_we,
  input  logic [DATA_W-1:0] smb_wdata,
  input  logic              hit,
  input  logic [SEL_W-1:0]  sel,
  input  logic [XA_W-1:0]   xa_dec,
  input  logic [DATA_W-1:0] xd_in,
  output logic              use_smb,
  output logic [N_CS-1:0]   cs_act,
  output logic              rd_strb,
  output logic              wr_strb,
  output logic [XA_W-1:0]   xa,
  output logic [DATA_W-1:0] xd_out,
  output logic              xd_oe,
  output logic              lpc_done,
  output logic              smb_done,
  output logic [DATA_W-1:0] rdata
);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              owner_q, we_q;
  logic [SEL_W-1:0]  sel_q;
  logic [XA_W-1:0]   xa_q;
  logic [DATA_W-1:0] wd_q, rdata_q, rdata_d;
  logic [1:0]        done_q, done_d;
  logic              accept, start, miss, cap_rd, rd_en, busy;

  // First come, first served; a same-cycle tie goes to the address side
  assign use_smb = smb_req && !lpc_req;
  assign accept  = (state_q == ST_IDLE) && (lpc_req || smb_req);
  assign start   = accept && hit;
  assign miss    = accept && !hit;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap_rd  = 1'b0;
    done_d  = 2'b00;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          cnt_d   = '0;
        end else if (miss) begin
          done_d = use_smb ? 2'b10 : 2'b01;
        end
      end
      ST_SETUP: begin
        if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
          state_d = ST_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt_q == CNT_W'(STROBE_CYC - 1)) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
          cap_rd  = !we_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          done_d  = owner_q ? 2'b10 : 2'b01;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rd_en   = cap_rd || miss;
  assign rdata_d = miss ? {DATA_W{1'b1}} : xd_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 2'b00;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= 1'b0;
      we_q    <= 1'b0;
      sel_q   <= '0;
      xa_q    <= '0;
      wd_q    <= '0;
    end else if (start) begin
      owner_q <= use_smb;
      we_q    <= use_smb ? smb_we : lpc_we;
      sel_q   <= sel;
      xa_q    <= xa_dec;
      wd_q    <= use_smb ? smb_wdata : lpc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  for (genvar i = 0; i < N_CS; i++) begin : g_act
    assign cs_act[i] = busy && (sel_q == SEL_W'(i));
  end

  assign rd_strb  = (state_q == ST_STROBE) && !we_q;
  assign wr_strb  = (state_q == ST_STROBE) && we_q;
  assign xa       = xa_q;
  assign xd_out   = wd_q;
  assign xd_oe    = busy && we_q;
  assign lpc_done = done_q[0];
  assign smb_done = done_q[1];
  assign rdata    = rdata_q;

endmodule

// File: rtl/pcb_bridge.sv
module pcb_bridge
  import pcb_pkg::*;
#(
  parameter int                N_CS        = 4,
  parameter logic [N_CS-1:0]   CS_ACT_HIGH = 4'b0010,
  parameter logic [N_CS-1:0]   LOCKABLE    = 4'b1110,
  parameter logic [4*N_CS-1:0] CMD_CODES   = 16'hDCBA,
  parameter logic [15:0]       BASE0_RST   = 16'h0080,
  parameter int                SETUP_CYC   = 2,
  parameter int                STROBE_CYC  = 4,
  parameter int                HOLD_CYC    = 1,
  localparam int               SEL_W       = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpc_req,
  input  logic              lpc_we,
  input  logic [15:0]       lpc_addr,
  input  logic [7:0]        lpc_wdata,
  output logic              lpc_done,
  input  logic              smb_req,
  input  logic              smb_we,
  input  logic [7:0]        smb_cmd,
  input  logic [7:0]        smb_wdata,
  output logic              smb_done,
  output logic [7:0]        rsp_rdata,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_hi,
  input  logic [7:0]        cfg_wdata,
  output logic [N_CS-1:0]   xcs,
  output logic [3:0]        xa,
  output logic              xrd_n,
  output logic              xwr_n,
  output logic [7:0]        xd_out,
  output logic              xd_oe,
  input  logic [7:0]        xd_in
);

  logic [1:0]                  rst_pipe_q;
  logic                        rst_sync_n;
  logic [N_CS-1:0][BASE_W-1:0] cfg_base;
  logic [N_CS-1:0]             cfg_enable;
  logic                        cfg_lock;
  logic                        use_smb, dec_hit, rd_strb, wr_strb;
  logic [SEL_W-1:0]            dec_sel;
  logic [XA_W-1:0]             dec_xa;
  logic [N_CS-1:0]             cs_act;

  // Reset asserts at once and leaves two clocks after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  pcb_cfg #(
    .N_CS      (N_CS),
    .LOCKABLE  (LOCKABLE),
    .BASE0_RST (BASE0_RST)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_hi    (cfg_hi),
    .cfg_wdata (cfg_wdata),
    .base      (cfg_base),
    .enable    (cfg_enable),
    .lock      (cfg_lock)
  );

  pcb_decode #(
    .N_CS      (N_CS),
    .CMD_CODES (CMD_CODES)
  ) u_dec (
    .use_smb  (use_smb),
    .lpc_addr (lpc_addr),
    .smb_cmd  (smb_cmd),
    .base     (cfg_base),
    .enable   (cfg_enable),
    .hit      (dec_hit),
    .sel      (dec_sel),
    .xa       (dec_xa)
  );

  pcb_seq #(
    .N_CS       (N_CS),
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lpc_req   (lpc_req),
    .lpc_we    (lpc_we),
    .lpc_wdata (lpc_wdata),
    .smb_req   (smb_req),
    .smb_we    (smb_we),
    .smb_wdata (smb_wdata),
    .hit       (dec_hit),
    .sel       (dec_sel),
    .xa_dec    (dec_xa),
    .xd_in     (xd_in),
    .use_smb   (use_smb),
    .cs_act    (cs_act),
    .rd_strb   (rd_strb),
    .wr_strb   (wr_strb),
    .xa        (xa),
    .xd_out    (xd_out),
    .xd_oe     (xd_oe),
    .lpc_done  (lpc_done),
    .smb_done  (smb_done),
    .rdata     (rsp_rdata)
  );

  // Pin level: active-high selects pass through, others are inverted
  assign xcs   = cs_act ^ ~CS_ACT_HIGH;
  assign xrd_n = !rd_strb;
  assign xwr_n = !wr_strb;

endmodule

// File: rtl/pcb_chk.sv
module pcb_chk #(
  parameter int              N_CS        = 4,
  parameter logic [N_CS-1:0] CS_ACT_HIGH = 4'b0010
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CS-1:0] xcs,
  input logic [3:0]      xa,
  input logic            xrd_n,
  input logic            xwr_n,
  input logic            xd_oe,
  input logic            lpc_done,
  input logic            smb_done,
  input logic            cfg_lock,
  input logic [N_CS-1:0] cfg_enable
);

  logic [N_CS-1:0] act;
  logic            strb;
  assign act  = xcs ^ ~CS_ACT_HIGH;
  assign strb = !xrd_n || !xwr_n;

  p_one_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!xrd_n && !xwr_n));

  p_strobe_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> (act != '0));

  p_oe_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xd_oe |-> (act != '0));

  p_xa_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && $past(strb)) |-> $stable(xa));

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(lpc_done && smb_done));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_lock) |-> cfg_lock);

  for (genvar i = 0; i < N_CS; i++) begin : g_en
    p_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act[i]) |-> $past(cfg_enable[i]));
  end

endmodule

bind pcb_bridge pcb_chk #(
  .N_CS        (N_CS),
  .CS_ACT_HIGH (CS_ACT_HIGH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .xcs        (xcs),
  .xa         (xa),
  .xrd_n      (xrd_n),
  .xwr_n      (xwr_n),
  .xd_oe      (xd_oe),
  .lpc_done   (lpc_done),
  .smb_done   (smb_done),
  .cfg_lock   (cfg_lock),
  .cfg_enable (cfg_enable)
);

// File: tb/sim_pcb_bridge.sv
module sim_pcb_bridge;

  localparam logic [3:0] IDLE_CS = 4'b1101;

  logic clk = 1'b0;
  logic rst_n;
  logic lpc_req, lpc_we, smb_req, smb_we, cfg_we, cfg_hi;
  logic [15:0] lpc_addr;
  logic [7:0]  lpc_wdata, smb_cmd, smb_wdata, cfg_wdata, xd_in;
  logic [1:0]  cfg_sel;
  logic        lpc_done, smb_done, xrd_n, xwr_n, xd_oe;
  logic [7:0]  rsp_rdata, xd_out;
  logic [3:0]  xcs, xa;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Bench-side model of the configuration state
  logic [13:0] m_base [4];
  bit          m_en   [4];
  bit          m_lock;

  always #2 clk = ~clk;

  pcb_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .lpc_req(lpc_req), .lpc_we(lpc_we), .lpc_addr(lpc_addr), .lpc_wdata(lpc_wdata),
    .lpc_done(lpc_done),
    .smb_req(smb_req), .smb_we(smb_we), .smb_cmd(smb_cmd), .smb_wdata(smb_wdata),
    .smb_done(smb_done), .rsp_rdata(rsp_rdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata),
    .xcs(xcs), .xa(xa), .xrd_n(xrd_n), .xwr_n(xwr_n),
    .xd_out(xd_out), .xd_oe(xd_oe), .xd_in(xd_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 14'h0;
      m_en[i]   = (i == 0);
    end
    m_base[0] = 14'h0020;  // 0x0080 >> 2
    m_lock    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  function automatic int exp_sel(input bit smb, input logic [15:0] a, input logic [7:0] c);
    for (int i = 0; i < 4; i++) begin
      if (m_en[i] && (smb ? (c[7:4] == 4'(4'hA + i)) : (a[15:2] == m_base[i]))) return i;
    end
    return -1;
  endfunction

  task automatic cfg_wr(input logic [1:0] s, input bit hi, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_hi = hi; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!(s != 0 && m_lock)) begin
      if (hi) m_base[s][13:6] = d;
      else begin
        m_base[s][5:0] = d[7:2];
        if (s != 0) m_en[s] = !d[0];
      end
    end
    if (!hi && s != 0 && d[1]) m_lock = 1'b1;
  endtask

  // One request, observed over nine cycles after the accepting edge
  task automatic access(input bit smb, input bit we, input logic [15:0] a,
                        input logic [7:0] c, input logic [7:0] wd, input string tag);
    int s;
    logic [7:0] rv;
    logic [3:0] xa_e, cs_e;
    logic [6:0] got, want;
    bit busy, strb, dn;
    s    = exp_sel(smb, a, c);
    rv   = 8'($urandom);
    xa_e = smb ? c[3:0] : {2'b00, a[1:0]};
    @(negedge clk);
    xd_in = rv;
    if (smb) begin smb_req = 1'b1; smb_we = we; smb_cmd = c; smb_wdata = wd; end
    else     begin lpc_req = 1'b1; lpc_we = we; lpc_addr = a; lpc_wdata = wd; end
    @(negedge clk);
    lpc_req = 1'b0; smb_req = 1'b0;
    for (int k = 1; k <= 9; k++) begin
      busy = (s >= 0) && k >= 1 && k <= 7;
      strb = (s >= 0) && k >= 3 && k <= 6;
      dn   = (s >= 0) ? (k == 8) : (k == 1);
      cs_e = IDLE_CS ^ (busy ? 4'(1 << s) : 4'b0);
      want = {cs_e, !(strb && !we), !(strb && we), busy && we};
      got  = {xcs, xrd_n, xwr_n, xd_oe};
      chk(got == want, {tag, " R5 R2 R6 pins"}, 32'(got), 32'(want));
      chk({lpc_done, smb_done} == {dn && !smb, dn && smb}, {tag, " R5 R11 done"},
          32'({lpc_done, smb_done}), 32'({dn && !smb, dn && smb}));
      if (s >= 0 && k == 3) chk(xa == xa_e, {tag, " R3 R4 xa"}, 32'(xa), 32'(xa_e));
      if (s >= 0 && we && k == 4) chk(xd_out == wd, {tag, " R6 xd_out"}, 32'(xd_out), 32'(wd));
      if (dn && s < 0) chk(rsp_rdata == 8'hFF, {tag, " R11 rdata"}, 32'(rsp_rdata), 32'hFF);
      if (dn && s >= 0 && !we) chk(rsp_rdata == rv, {tag, " R5 rdata"}, 32'(rsp_rdata), 32'(rv));
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int nl, ns;
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    lpc_req = 0; lpc_we = 0; lpc_addr = 0; lpc_wdata = 0;
    smb_req = 0; smb_we = 0; smb_cmd = 0; smb_wdata = 0;
    cfg_we = 0; cfg_sel = 0; cfg_hi = 0; cfg_wdata = 0; xd_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 while in reset
    chk({xcs, xrd_n, xwr_n, xd_oe, lpc_done, smb_done} == {IDLE_CS, 5'b11000}, "R1 in reset",
        32'({xcs, xrd_n, xwr_n, xd_oe, lpc_done, smb_done}), 32'({IDLE_CS, 5'b11000}));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({xcs, xrd_n, xwr_n, xd_oe, lpc_done, smb_done} == {IDLE_CS, 5'b11000}, "R1 after reset",
        32'({xcs, xrd_n, xwr_n, xd_oe, lpc_done, smb_done}), 32'({IDLE_CS, 5'b11000}));

    // R9: select 0 at 0x0080 from reset; R4 command path
    access(0, 0, 16'h0081, 8'h00, 8'h00, "R9 sel0 reset base");
    access(1, 1, 16'h0000, 8'hA5, 8'h3C, "R4 smb write sel0");
    // R7: select 1 disabled out of reset, even with base programmed
    cfg_wr(2'd1, 1, 8'h03);
    cfg_wr(2'd1, 0, 8'h01);
    access(0, 0, 16'h0302, 8'h00, 8'h00, "R7 R11 disabled sel1");
    access(1, 0, 16'h0000, 8'hB2, 8'h00, "R7 R11 disabled sel1 smb");
    cfg_wr(2'd1, 0, 8'h00);
    access(0, 0, 16'h0302, 8'h00, 8'h00, "R2 R7 enabled sel1 high");
    access(0, 1, 16'h0303, 8'h00, 8'h5A, "R6 write sel1");
    // R12: sel2 and sel3 share a base, sel2 wins
    cfg_wr(2'd3, 1, 8'h04); cfg_wr(2'd3, 0, 8'h10);
    cfg_wr(2'd2, 1, 8'h04); cfg_wr(2'd2, 0, 8'h10);
    access(0, 0, 16'h0411, 8'h00, 8'h00, "R12 overlap sel2");
    cfg_wr(2'd2, 0, 8'h20);
    access(0, 0, 16'h0412, 8'h00, 8'h00, "R2 sel3 low active");
    // R8: set the latch; later writes blocked
    cfg_wr(2'd3, 0, 8'h12);
    cfg_wr(2'd3, 1, 8'h07);
    cfg_wr(2'd1, 0, 8'h01);
    cfg_wr(2'd3, 0, 8'h00);
    access(0, 0, 16'h0410, 8'h00, 8'h00, "R8 sel3 base kept");
    access(0, 0, 16'h0301, 8'h00, 8'h00, "R8 sel1 disable blocked");
    access(0, 0, 16'h0710, 8'h00, 8'h00, "R8 blocked base not taken");
    // R9: select 0 still writable, its low control bits ignored
    cfg_wr(2'd0, 1, 8'h02); cfg_wr(2'd0, 0, 8'h03);
    access(0, 0, 16'h0201, 8'h00, 8'h00, "R9 sel0 rewritten");
    access(0, 0, 16'h0081, 8'h00, 8'h00, "R9 R11 old sel0 base");
    // R8: only reset unlocks
    do_reset();
    cfg_wr(2'd1, 1, 8'h05); cfg_wr(2'd1, 0, 8'h00);
    access(0, 0, 16'h0500, 8'h00, 8'h00, "R8 unlocked after reset");

    // R10: same-cycle tie, address side served
    @(negedge clk);
    lpc_req = 1; lpc_we = 0; lpc_addr = 16'h0080; smb_req = 1; smb_we = 0; smb_cmd = 8'hB1;
    @(negedge clk);
    lpc_req = 0; smb_req = 0;
    nl = 0; ns = 0;
    for (int k = 0; k < 12; k++) begin
      nl += int'(lpc_done); ns += int'(smb_done);
      @(negedge clk);
    end
    chk(nl == 1 && ns == 0, "R10 tie", 32'({nl[15:0], ns[15:0]}), 32'h00010000);
    // R10: request during a busy bus is dropped
    @(negedge clk);
    lpc_req = 1; lpc_addr = 16'h0500;
    @(negedge clk);
    lpc_req = 0;
    @(negedge clk);
    smb_req = 1; smb_cmd = 8'hA0;
    @(negedge clk);
    smb_req = 0;
    nl = 0; ns = 0;
    for (int k = 0; k < 12; k++) begin
      nl += int'(lpc_done); ns += int'(smb_done);
      @(negedge clk);
    end
    chk(nl == 1 && ns == 0, "R10 busy drop", 32'({nl[15:0], ns[15:0]}), 32'h00010000);

    // Random mix of configuration writes and accesses
    for (int n = 0; n < 160; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [7:0] d;
        d = 8'($urandom);
        if ($urandom_range(0, 7) != 0) d[1] = 1'b0;
        cfg_wr(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), d);
      end else begin
        bit smb;
        logic [15:0] a;
        logic [7:0] c;
        int s;
        smb = 1'($urandom_range(0, 1));
        s   = $urandom_range(0, 3);
        a   = ($urandom_range(0, 9) < 7) ? {m_base[s], 2'($urandom)} : 16'($urandom);
        c   = {4'($urandom_range(9, 13)), 4'($urandom)};
        access(smb, 1'($urandom_range(0, 1)), a, c, 8'($urandom), "R3 R4 R12 random");
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule